// File: doc/BRIEF.md
# Serial Byte-Addressed Memory Slave

This block is the slave side of a four-wire serial memory. It fronts a 2048-byte array. A host selects it with an active-low chip select and clocks it in SPI mode 0. The first byte of every selection is a command. Two commands move data. Read and write each carry the three high address bits inside the command byte, and the following byte gives the low eight bits. After that, bytes stream without limit in the chosen direction while the address counts up and wraps around. Each incoming write byte lands in the array as soon as its last bit arrives, provided the protection logic allows it. Four more commands set or clear a write-enable flag, read the status byte, or write the status byte.

Protection works on three levels. A write-enable flag gates every store. A two-bit field locks the top quarter, the top half or the whole array. A lock-enable bit, combined with a low level on the write-protect pin, freezes the status byte. An active-low hold pin pauses a transfer in place without ending it. All serial pins are sampled with the system clock, so the serial clock must be several system clocks slower than the system clock. The serial clock is never used as a clock inside the block.

Top module: `sermem_slave`

## Requirements
- R1: A command byte must have bits 7:6 equal to 00. Bits 2:0 select the command: 110 sets write-enable, 100 clears write-enable, 101 reads status, 001 writes status, 011 reads memory, 010 writes memory. Any other byte is an undefined command.
- R2: For read and write, command bits 5:3 form address bits 10:8 and the next byte forms address bits 7:0.
- R3: SI is sampled on the rising SCK edge and SO changes on the falling SCK edge. Bytes move most significant bit first in both directions.
- R4: A write data byte is stored when its eighth bit is received, if protection allows it. Any number of bytes may follow. A byte left with fewer than eight bits when chip select rises is never stored.
- R5: The address advances by one after every data byte, in both directions, and wraps from 7FFh to 000h.
- R6: During a read, SI is ignored once the address byte is complete. One data bit is driven out per SCK cycle.
- R7: The set-write-enable command raises the write-enable flag and the clear command lowers it. While the flag is low, neither the memory nor the status byte can be written.
- R8: Status bits 3:2 lock memory addresses: 00 locks none, 01 locks 600h–7FFh, 10 locks 400h–7FFh, 11 locks every address.
- R9: The status byte reads as {lock-enable, 000, bits 3:2, write-enable, 0} and reads 00h after reset. A status write loads only bit 7 and bits 3:2. It is refused when bit 7 is 1 and wp_n is low.
- R10: hold_n taken low while SCK is low pauses the transfer. SCK edges are ignored until hold_n returns high while SCK is low, and the transfer then continues where it stopped.
- R11: so_en is low whenever chip select is high or hold is in effect.
- R12: A rising chip select ends any operation. After an undefined command, every later bit in that selection is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low write-protect pin for the status byte |
| so_d | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for so_d; low means high impedance |

## Verification
The checks assume that every serial pin holds steady for longer than the synchronizer depth plus one system clock. They also assume that hold_n and chip select change only while SCK is low. The stimulus uses SCK half-periods of six system clocks. It toggles hold_n and chip select only inside a low SCK phase, and it sets SI before each rising edge. Under those rules, no serial edge can be lost or doubled inside the block.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_STOUT,
    PH_STIN,
    PH_DROP
  } phase_e;

  localparam logic [2:0] CODE_WEN   = 3'b110;
  localparam logic [2:0] CODE_WDIS  = 3'b100;
  localparam logic [2:0] CODE_RSTAT = 3'b101;
  localparam logic [2:0] CODE_WSTAT = 3'b001;
  localparam logic [2:0] CODE_READ  = 3'b011;
  localparam logic [2:0] CODE_WRITE = 3'b010;

endpackage

// File: rtl/sermem_pinsync.sv
module sermem_pinsync #(
  parameter int N = 5,
  parameter int STAGES = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/sermem_guard.sv
module sermem_guard #(
  parameter int ADDR_W = 11,
  localparam int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_s,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              st_we,
  input  logic [BYTE_W-1:0] st_wdata,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [BYTE_W-1:0] status,
  output logic              mem_ok,
  output logic              st_ok
);

  logic       wel;
  logic       lock_en;
  logic [1:0] zone;
  logic       zone_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      lock_en <= 1'b0;
      zone    <= 2'b00;
    end else begin
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (st_we && st_ok) begin
        lock_en <= st_wdata[7];
        zone    <= st_wdata[3:2];
      end
    end
  end

  always_comb begin
    case (zone)
      2'b00:   zone_hit = 1'b0;
      2'b01:   zone_hit = &chk_addr[ADDR_W-1:ADDR_W-2];
      2'b10:   zone_hit = chk_addr[ADDR_W-1];
      default: zone_hit = 1'b1;
    endcase
  end

  assign mem_ok = wel && !zone_hit;
  assign st_ok  = wel && !(lock_en && !wp_n_s);
  assign status = {lock_en, 3'b000, zone, wel, 1'b0};

  // R7
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable({lock_en, zone}));

  // R9
  pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && !wp_n_s) |=> $stable({lock_en, zone}));

  // R8
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zone == 2'b11) |-> !mem_ok);

endmodule

// File: rtl/sermem_ram.sv
module sermem_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/sermem_slave.sv
module sermem_slave
  import sermem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so_d,
  output logic so_en
);

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [4:0] pins_raw, pins_s;
  logic cs_s, sck_s, si_s, hold_s, wp_s;

  assign pins_raw = {wp_n, hold_n, si, sck, cs_n};

  sermem_pinsync #(.N(5), .STAGES(SYNC_STAGES), .INIT(5'b11001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign {wp_s, hold_s, si_s, sck_s, cs_s} = pins_s;

  logic sck_d;
  logic held;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (cs_s)        held <= 1'b0;
      else if (!sck_s) held <= !hold_s;
    end
  end

  assign rise = sck_s && !sck_d && !held && !cs_s;
  assign fall = !sck_s && sck_d && !held && !cs_s;

  phase_e              phase;
  logic [CNT_W-1:0]    bcnt;
  logic [BYTE_W-1:0]   shin;
  logic [ADDR_W-1:0]   addr;
  logic                rd_dir;
  logic [BYTE_W-1:0]   rx_byte;
  logic                byte_done;
  logic                cmd_ok;

  assign rx_byte   = {shin[BYTE_W-2:0], si_s};
  assign byte_done = rise && (bcnt == LAST_BIT);
  assign cmd_ok    = (rx_byte[7:6] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      bcnt   <= '0;
      shin   <= '0;
      addr   <= '0;
      rd_dir <= 1'b0;
    end else if (cs_s) begin
      phase <= PH_CMD;
      bcnt  <= '0;
    end else begin
      if (rise) begin
        bcnt <= bcnt + 1'b1;
        shin <= rx_byte;
      end
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            if (!cmd_ok) phase <= PH_DROP;
            else begin
              case (rx_byte[2:0])
                CODE_READ, CODE_WRITE: begin
                  addr[ADDR_W-1 -: HI_W] <= rx_byte[3 +: HI_W];
                  rd_dir <= (rx_byte[2:0] == CODE_READ);
                  phase  <= PH_ADDR;
                end
                CODE_RSTAT: phase <= PH_STOUT;
                CODE_WSTAT: phase <= PH_STIN;
                default:    phase <= PH_DROP;
              endcase
            end
          end
          PH_ADDR: begin
            addr[BYTE_W-1:0] <= rx_byte;
            phase <= rd_dir ? PH_RDATA : PH_WDATA;
          end
          PH_WDATA, PH_RDATA: addr <= addr + 1'b1;
          PH_STIN:            phase <= PH_DROP;
          default: ;
        endcase
      end
    end
  end

  logic              set_wel, clr_wel, st_we, mem_ok, st_ok, mem_we;
  logic [BYTE_W-1:0] status;
  logic [BYTE_W-1:0] ram_q;

  assign set_wel = byte_done && (phase == PH_CMD) && cmd_ok && (rx_byte[2:0] == CODE_WEN);
  assign clr_wel = byte_done && (phase == PH_CMD) && cmd_ok && (rx_byte[2:0] == CODE_WDIS);
  assign st_we   = byte_done && (phase == PH_STIN);
  assign mem_we  = byte_done && (phase == PH_WDATA) && mem_ok;

  sermem_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n_s   (wp_s),
    .set_wel  (set_wel),
    .clr_wel  (clr_wel),
    .st_we    (st_we),
    .st_wdata (rx_byte),
    .chk_addr (addr),
    .status   (status),
    .mem_ok   (mem_ok),
    .st_ok    (st_ok)
  );

  sermem_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr),
    .wdata (rx_byte),
    .raddr (addr),
    .rdata (ram_q)
  );

  logic [BYTE_W-1:0] obuf;
  logic [BYTE_W-1:0] osrc;
  logic              so_q;

  assign osrc = (phase == PH_STOUT) ? status : ram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf <= '0;
      so_q <= 1'b0;
    end else if (cs_s) begin
      so_q <= 1'b0;
    end else if (fall && (phase == PH_RDATA || phase == PH_STOUT)) begin
      if (bcnt == '0) begin
        so_q <= osrc[BYTE_W-1];
        obuf <= {osrc[BYTE_W-2:0], 1'b0};
      end else begin
        so_q <= obuf[BYTE_W-1];
        obuf <= {obuf[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign so_d  = so_q;
  assign so_en = !cs_s && !held;

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_s) |=> (cs_s || ($stable(bcnt) && $stable(so_q))));

  // R11
  so_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s || held) |-> !so_en);

  // R12
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DROP) |=> (phase == PH_DROP || phase == PH_CMD));

  // R5
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_WDATA || phase == PH_RDATA) && (&addr)) |=> (addr == '0));

  // R7
  wel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> status[1]);

endmodule

// File: tb/sermem_slave_test.sv
module sermem_slave_test;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so_d, so_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mem_m [2048];
  bit         wel_m = 0, lock_m = 0;
  logic [1:0] zone_m = 2'b00;

  always #2.5 clk = ~clk;

  sermem_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so_d(so_d), .so_en(so_en)
  );

  task automatic check_eq(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // R11: so_en must be low once chip select has been high for a few clocks
  int cs_hi_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
      if (cs_hi_cnt >= 4) check_eq("R11 so_en while deselected", {7'b0, so_en}, 8'h00);
    end
  end

  task automatic report;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  function automatic bit locked(input int a);
    case (zone_m)
      2'b00: return 0;
      2'b01: return a >= 'h600;
      2'b10: return a >= 'h400;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] stat_m();
    return {lock_m, 3'b000, zone_m, wel_m, 1'b0};
  endfunction

  // R3: mode 0, MSB first; optional hold inserted before bit index hold_at
  task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                      output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      si = tx[7-i];
      repeat (HALF) @(negedge clk);
      if (i == hold_at) begin
        hold_n = 1'b0;
        repeat (HALF) @(negedge clk);
        check_eq("R11 so_en during hold", {7'b0, so_en}, 8'h00);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; repeat (HALF) @(negedge clk);
          sck = 1'b0; repeat (HALF) @(negedge clk);
        end
        check_eq("R10 so_en still held after SCK toggles", {7'b0, so_en}, 8'h00);
        hold_n = 1'b1;
        repeat (HALF) @(negedge clk);
      end
      rx[7-i] = so_d;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic simple_cmd(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, 8, -1, r); desel();
    if (op == 8'h06) wel_m = 1;
    if (op == 8'h04) wel_m = 0;
  endtask

  task automatic rd_status(input string tag);
    logic [7:0] r;
    sel(); xfer(8'h05, 8, -1, r);
    xfer(8'h00, 8, -1, r); check_eq(tag, r, stat_m());
    xfer(8'hFF, 8, -1, r); check_eq({tag, " repeat"}, r, stat_m());
    desel();
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, 8, -1, r); xfer(v, 8, -1, r); desel();
    if (wel_m && !(lock_m && !wp_n)) begin
      lock_m = v[7];
      zone_m = v[3:2];
    end
  endtask

  // R2: opcode bits 5:3 = A10:A8
  task automatic wr_mem(input int a, input logic [7:0] d[$]);
    logic [7:0] r;
    int p = a;
    sel();
    xfer({2'b00, 3'(a >> 8), 3'b010}, 8, -1, r);
    xfer(8'(a), 8, -1, r);
    foreach (d[i]) begin
      xfer(d[i], 8, -1, r);
      if (wel_m && !locked(p)) mem_m[p] = d[i];
      p = (p + 1) % 2048;
    end
    desel();
  endtask

  task automatic rd_mem(input string tag, input int a, input int n, input int hold_byte);
    logic [7:0] r;
    int p = a;
    sel();
    xfer({2'b00, 3'(a >> 8), 3'b011}, 8, -1, r);
    xfer(8'(a), 8, -1, r);
    for (int i = 0; i < n; i++) begin
      xfer(8'hA5 ^ 8'(i * 37), 8, (i == hold_byte) ? 3 : -1, r);
      check_eq($sformatf("%s addr %03h", tag, p), r, mem_m[p]);
      p = (p + 1) % 2048;
    end
    desel();
  endtask

  initial begin
    logic [7:0] r;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    check_eq("R11 so_en after reset", {7'b0, so_en}, 8'h00);
    rd_status("R9 status after reset");

    simple_cmd(8'h06);
    rd_status("R7 write-enable set");
    wr_mem('h123, '{8'h11, 8'h22, 8'h33});
    rd_mem("R4 R2 R3 R6 stream readback", 'h123, 3, -1);
    wr_mem('h600, '{8'hC0});
    wr_mem('h400, '{8'hD0});
    wr_mem('h010, '{8'hE0});

    simple_cmd(8'h04);
    rd_status("R7 write-enable cleared");
    wr_mem('h123, '{8'h99});
    rd_mem("R7 store refused without enable", 'h123, 1, -1);
    wr_status(8'h0C);
    rd_status("R7 status write refused without enable");

    simple_cmd(8'h06);
    wr_mem('h7FE, '{8'hA1, 8'hA2, 8'hA3, 8'hA4});
    rd_mem("R5 wrap on read", 'h7FE, 4, -1);

    wr_status(8'h04);
    rd_status("R9 zone 01 loaded");
    wr_mem('h5FF, '{8'h5A, 8'h6B});
    rd_mem("R8 zone 01 locks 600h up", 'h5FF, 2, -1);

    wr_status(8'h08);
    wr_mem('h3FF, '{8'h77, 8'h88});
    rd_mem("R8 zone 10 locks 400h up", 'h3FF, 2, -1);

    wr_status(8'h0C);
    wr_mem('h010, '{8'h12});
    rd_mem("R8 zone 11 locks all", 'h010, 1, -1);

    wr_status(8'h8C);
    rd_status("R9 lock-enable loaded");
    wp_n = 1'b0;
    repeat (HALF) @(negedge clk);
    wr_status(8'h00);
    rd_status("R9 status frozen by pin");
    wp_n = 1'b1;
    repeat (HALF) @(negedge clk);
    wr_status(8'h70);
    rd_status("R9 only bits 7 and 3:2 written");

    // R4: partial byte discarded at chip-select rise
    sel();
    xfer(8'h0A, 8, -1, r);
    xfer(8'h23, 8, -1, r);
    xfer(8'hFF, 5, -1, r);
    desel();
    rd_mem("R4 partial byte not stored", 'h123, 1, -1);

    // R1 R12: undefined commands ignore the rest of the selection
    sel();
    xfer(8'hC2, 8, -1, r);
    xfer(8'h23, 8, -1, r);
    xfer(8'h55, 8, -1, r);
    desel();
    sel();
    xfer(8'h07, 8, -1, r);
    xfer(8'h06, 8, -1, r);
    xfer(8'h01, 8, -1, r);
    xfer(8'h8C, 8, -1, r);
    desel();
    rd_mem("R1 R12 undefined command ignored", 'h123, 1, -1);
    rd_status("R12 status untouched after undefined command");

    // R10: hold in the middle of a read byte
    wr_mem('h2A0, '{8'h3C, 8'hC3, 8'h96});
    rd_mem("R10 read across hold", 'h2A0, 3, 1);

    // R12: chip-select rise ends a write stream mid-way; next command runs normally
    sel();
    xfer(8'h12, 8, -1, r);
    xfer(8'hA0, 8, -1, r);
    xfer(8'h4E, 8, -1, r);
    desel();
    mem_m['h2A0] = 8'h4E;
    rd_mem("R12 new operation after rise", 'h2A0, 2, -1);

    report();
  end

endmodule